// File: doc/BRIEF.md
# 8b/10b Symbol Decoder with Disparity and Code Checking

This block takes one 10-bit line symbol on every clock and turns it back into the byte that was encoded. It also reports whether the symbol was a control character. The decoder keeps a running-disparity bit of its own, separate from the one the far-end transmitter holds. It uses this bit to judge the polarity of every incoming symbol.

Two kinds of fault are detected. The first is a code violation: the pattern appears in neither the data code space nor the control code space. The second is a disparity error: the symbol is a legal pattern, but its ones/zeros imbalance leans the same way as the current running disparity. Either fault raises a single receiver-error output. Symbol alignment and descrambling are done elsewhere; the symbol is assumed to arrive already framed.

The symbol word maps onto the line bits in transmit order. `symIn[9]` is the first bit on the wire and `symIn[0]` is the last. The upper six bits form the 6-bit sub-block and the lower four bits form the 4-bit sub-block. All code values below are written with the first line bit on the left.

Top module: `dec8b10b`

## Requirements
- R1: While `rstN` is low, all outputs read zero. Running disparity comes out of reset negative (parameter `RD_INIT` = 0). So a first symbol with four ones, such as 1100000101, is flagged as a disparity error.
- R2: Every legal data symbol from either disparity column decodes to its byte. `dataOut[4:0]` holds the 5-bit sub-block value and `dataOut[7:5]` holds the 3-bit sub-block value. `kOut` is 0, and the result appears one clock after the symbol is sampled.
- R3: Twelve control characters decode with `kOut` = 1. These are byte 0x1C with any upper three bits (0x1C, 0x3C, 0x5C, 0x7C, 0x9C, 0xBC, 0xDC, 0xFC), plus 0xF7, 0xFB, 0xFD and 0xFE. They are decoded in both disparity forms; for example 0011111010 and 1100000101 both give 0xBC.
- R4: After every symbol, the running disparity becomes positive if the symbol has six ones and negative if it has four ones. It is held for any other ones count. This rule applies to illegal patterns as well.
- R5: A legal symbol with six ones while the running disparity is positive raises `dispErr`. A legal symbol with four ones while it is negative also raises `dispErr`. A legal balanced symbol never raises it.
- R6: A pattern outside both code spaces raises `codeErr`. It also forces `dataOut` to 0x00 and `kOut` to 0, and it never raises `dispErr`.
- R7: After a disparity error, the running disparity follows the offending symbol's polarity. A correctly encoded symbol that follows is therefore accepted without error.
- R8: `rxErr` is high in exactly the cycles where `codeErr` or `dispErr` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| symIn | input | 10 | Aligned line symbol, bit 9 first on the wire |
| dataOut | output | 8 | Recovered byte, registered |
| kOut | output | 1 | Control-character flag, registered |
| codeErr | output | 1 | Code-violation flag, registered |
| dispErr | output | 1 | Disparity-error flag, registered |
| rxErr | output | 1 | Combined receiver error, registered |

## Verification
The hardest condition to reach from the ports is a disparity error. It needs a pattern that is legal in the code space, arriving while the hidden disparity bit points the same way as that pattern's polarity. A correct encoder never produces this.

The stimulus tracks the running disparity in a bench model. For each byte, it sends the encoding from the opposite column and then the correct one, which exercises both detection and recovery. It also sends illegal patterns with six and four ones to push the hidden bit to a chosen state before a legal symbol is checked.

// File: rtl/dec8b10b_pkg.sv
package dec8b10b_pkg;

  localparam int SYM_W  = 10;
  localparam int SUB6_W = 6;
  localparam int SUB4_W = SYM_W - SUB6_W;
  localparam int LOW_W  = 5;
  localparam int HIGH_W = 3;
  localparam int BYTE_W = LOW_W + HIGH_W;
  localparam int LOW_N  = 1 << LOW_W;
  localparam int HIGH_N = 1 << HIGH_W;
  localparam int CNT_W  = $clog2(SYM_W + 1);

  localparam logic [LOW_W-1:0]  CTRL_LOW  = 5'd28;
  localparam logic [HIGH_W-1:0] HIGH_MAX  = HIGH_W'(HIGH_N - 1);
  localparam logic [SUB6_W-1:0] CTRL6_NEG = 6'b001111;
  localparam logic [CNT_W-1:0]  HEAVY_CNT = CNT_W'(6);
  localparam logic [CNT_W-1:0]  LIGHT_CNT = CNT_W'(4);

  // Classification of the current symbol, datapath -> control
  typedef struct packed {
    logic legal;   // found in data or control code space
    logic heavy;   // six ones
    logic light;   // four ones
  } symClass_t;

  // Strobes, control -> datapath
  typedef struct packed {
    logic zeroOut; // load zero byte / clear K instead of decoded value
  } dpStrobe_t;

  // 6-bit code used when disparity entering the sub-block is negative
  function automatic logic [SUB6_W-1:0] low6Neg(input logic [LOW_W-1:0] x);
    logic [SUB6_W-1:0] c;
    case (x)
      5'd0:  c = 6'b100111;  5'd1:  c = 6'b011101;
      5'd2:  c = 6'b101101;  5'd3:  c = 6'b110001;
      5'd4:  c = 6'b110101;  5'd5:  c = 6'b101001;
      5'd6:  c = 6'b011001;  5'd7:  c = 6'b111000;
      5'd8:  c = 6'b111001;  5'd9:  c = 6'b100101;
      5'd10: c = 6'b010101;  5'd11: c = 6'b110100;
      5'd12: c = 6'b001101;  5'd13: c = 6'b101100;
      5'd14: c = 6'b011100;  5'd15: c = 6'b010111;
      5'd16: c = 6'b011011;  5'd17: c = 6'b100011;
      5'd18: c = 6'b010011;  5'd19: c = 6'b110010;
      5'd20: c = 6'b001011;  5'd21: c = 6'b101010;
      5'd22: c = 6'b011010;  5'd23: c = 6'b111010;
      5'd24: c = 6'b110011;  5'd25: c = 6'b100110;
      5'd26: c = 6'b010110;  5'd27: c = 6'b110110;
      5'd28: c = 6'b001110;  5'd29: c = 6'b101110;
      5'd30: c = 6'b011110;  default: c = 6'b101011;
    endcase
    return c;
  endfunction

  // Sub-blocks whose positive-entry code is the complement of the negative one
  function automatic logic low6Flips(input logic [LOW_W-1:0] x);
    return x inside {5'd0, 5'd1, 5'd2, 5'd4, 5'd7, 5'd8, 5'd15, 5'd16,
                     5'd23, 5'd24, 5'd27, 5'd29, 5'd30, 5'd31};
  endfunction

  // 4-bit code for negative entry; alt selects the alternate form of value 7
  function automatic logic [SUB4_W-1:0] high4Base(input logic [HIGH_W-1:0] y,
                                                  input logic alt);
    logic [SUB4_W-1:0] c;
    case (y)
      3'd0: c = 4'b1011;
      3'd1: c = 4'b1001;
      3'd2: c = 4'b0101;
      3'd3: c = 4'b1100;
      3'd4: c = 4'b1101;
      3'd5: c = 4'b1010;
      3'd6: c = 4'b0110;
      default: c = alt ? 4'b0111 : 4'b1110;
    endcase
    return c;
  endfunction

  function automatic logic high4Flips(input logic [HIGH_W-1:0] y);
    return y inside {3'd0, 3'd3, 3'd4, 3'd7};
  endfunction

  // Low values that may carry a control character with upper value 7
  function automatic logic ctrlAlt7Low(input logic [LOW_W-1:0] x);
    return x inside {5'd23, 5'd27, 5'd29, 5'd30};
  endfunction

  // Reference encoding of one character for a given entry disparity
  function automatic logic [SYM_W-1:0] encodeSym(input logic [BYTE_W-1:0] b,
                                                 input logic isK,
                                                 input logic rdIn);
    logic [LOW_W-1:0]  x;
    logic [HIGH_W-1:0] y;
    logic              k28;
    logic              rdMid;
    logic              alt7;
    logic [SUB6_W-1:0] c6;
    logic [SUB4_W-1:0] c4;
    x   = b[LOW_W-1:0];
    y   = b[BYTE_W-1:LOW_W];
    k28 = isK && (x == CTRL_LOW);
    c6  = k28 ? CTRL6_NEG : low6Neg(x);
    if (rdIn && (k28 || low6Flips(x))) c6 = ~c6;
    rdMid = rdIn ^ ($countones(c6) != 3);
    alt7  = isK || (!rdMid && (x inside {5'd17, 5'd18, 5'd20}))
                || ( rdMid && (x inside {5'd11, 5'd13, 5'd14}));
    c4 = high4Base(y, alt7);
    if (high4Flips(y)) begin
      if (rdMid) c4 = ~c4;
    end else if (k28 && !rdMid) begin
      c4 = ~c4;
    end
    return {c6, c4};
  endfunction

endpackage

// File: rtl/dec8b10b_datapath.sv
module dec8b10b_datapath
  import dec8b10b_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [SYM_W-1:0]  symIn,
  input  dpStrobe_t         strobe,
  output symClass_t         cls,
  output logic [BYTE_W-1:0] dataQ,
  output logic              kQ
);

  logic [SUB6_W-1:0] sub6;
  logic [SUB4_W-1:0] sub4;
  logic [SUB4_W-1:0] sub4Norm;
  logic              ctrl28;
  logic [LOW_N-1:0]  lowHit;
  logic [HIGH_N-1:0] highHit;
  logic [LOW_W-1:0]  lowVal;
  logic [HIGH_W-1:0] highVal;
  logic              lowOk;
  logic              highOk;
  logic              isAlt7;
  logic              isK;
  logic [BYTE_W-1:0] byteVal;
  logic              reMatch;
  logic [CNT_W-1:0]  onesCnt;

  assign sub6   = symIn[SYM_W-1 -: SUB6_W];
  assign sub4   = symIn[SUB4_W-1:0];
  assign ctrl28 = (sub6 == CTRL6_NEG) || (sub6 == ~CTRL6_NEG);
  // the positive-entry control prefix carries a complemented 4-bit tail
  assign sub4Norm = (sub6 == ~CTRL6_NEG) ? ~sub4 : sub4;

  generate
    for (genvar g = 0; g < LOW_N; g++) begin : gLow
      localparam logic [LOW_W-1:0] XV = LOW_W'(g);
      assign lowHit[g] = (sub6 == low6Neg(XV)) ||
                         (low6Flips(XV) && (sub6 == ~low6Neg(XV)));
    end
    for (genvar g = 0; g < HIGH_N; g++) begin : gHigh
      localparam logic [HIGH_W-1:0] YV = HIGH_W'(g);
      assign highHit[g] = (sub4Norm == high4Base(YV, 1'b0)) ||
                          (high4Flips(YV) && (sub4Norm == ~high4Base(YV, 1'b0))) ||
                          ((YV == HIGH_MAX) &&
                           ((sub4Norm == high4Base(YV, 1'b1)) ||
                            (sub4Norm == ~high4Base(YV, 1'b1))));
    end
  endgenerate

  always_comb begin : lowEncode
    lowVal = '0;
    for (int i = 0; i < LOW_N; i++) begin
      if (lowHit[i]) lowVal = LOW_W'(i);
    end
    if (ctrl28) lowVal = CTRL_LOW;
  end

  always_comb begin : highEncode
    highVal = '0;
    for (int i = 0; i < HIGH_N; i++) begin
      if (highHit[i]) highVal = HIGH_W'(i);
    end
  end

  assign lowOk   = ctrl28 || (|lowHit);
  assign highOk  = |highHit;
  assign isAlt7  = (sub4Norm == high4Base(HIGH_MAX, 1'b1)) ||
                   (sub4Norm == ~high4Base(HIGH_MAX, 1'b1));
  assign isK     = ctrl28 || (isAlt7 && ctrlAlt7Low(lowVal));
  assign byteVal = {highVal, lowVal};
  // membership: the pattern must equal one of the two legal spellings
  assign reMatch = (symIn == encodeSym(byteVal, isK, 1'b0)) ||
                   (symIn == encodeSym(byteVal, isK, 1'b1));
  assign onesCnt = CNT_W'($countones(symIn));

  assign cls.legal = lowOk && highOk && reMatch;
  assign cls.heavy = (onesCnt == HEAVY_CNT);
  assign cls.light = (onesCnt == LIGHT_CNT);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataQ <= '0;
      kQ    <= 1'b0;
    end else if (strobe.zeroOut) begin
      dataQ <= '0;
      kQ    <= 1'b0;
    end else begin
      dataQ <= byteVal;
      kQ    <= isK;
    end
  end

  // R6: a zeroing strobe leaves a zero byte and a low K flag next cycle
  p_zero_on_viol_r6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.zeroOut |=> (dataQ == '0) && !kQ);

  // R3: the K flag only accompanies one of the twelve control bytes
  p_k_set_r3: assert property (@(posedge clk) disable iff (!rstN)
    kQ |-> ((dataQ[LOW_W-1:0] == CTRL_LOW) ||
            (dataQ inside {8'hF7, 8'hFB, 8'hFD, 8'hFE})));

endmodule

// File: rtl/dec8b10b_control.sv
module dec8b10b_control
  import dec8b10b_pkg::*;
#(
  parameter bit RD_INIT = 1'b0
)(
  input  logic      clk,
  input  logic      rstN,
  input  symClass_t cls,
  output dpStrobe_t strobe,
  output logic      codeErrQ,
  output logic      dispErrQ,
  output logic      rxErrQ
);

  logic rdQ;
  logic rdNext;
  logic dispHit;
  logic codeHit;

  assign codeHit = !cls.legal;
  // polarity matching the running disparity is illegal; balanced never is
  assign dispHit = cls.legal && ((cls.heavy && rdQ) || (cls.light && !rdQ));
  // follow the symbol's own polarity; this also resynchronises after errors
  assign rdNext  = cls.heavy ? 1'b1 : (cls.light ? 1'b0 : rdQ);

  assign strobe.zeroOut = codeHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdQ      <= RD_INIT;
      codeErrQ <= 1'b0;
      dispErrQ <= 1'b0;
      rxErrQ   <= 1'b0;
    end else begin
      rdQ      <= rdNext;
      codeErrQ <= codeHit;
      dispErrQ <= dispHit;
      rxErrQ   <= codeHit || dispHit;
    end
  end

  // R4: a legal unbalanced symbol without error flips the tracker
  p_rd_flip_r4: assert property (@(posedge clk) disable iff (!rstN)
    (cls.legal && (cls.heavy || cls.light) && !dispHit) |=> (rdQ != $past(rdQ)));

  // R4: neither six nor four ones leaves the tracker alone
  p_rd_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!cls.heavy && !cls.light) |=> $stable(rdQ));

  // R5: heavy legal symbol on positive disparity is reported
  p_disp_detect_r5: assert property (@(posedge clk) disable iff (!rstN)
    (cls.legal && cls.heavy && rdQ) |=> dispErrQ);

  // R5: balanced symbols never produce a disparity error
  p_bal_no_disp_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!cls.heavy && !cls.light) |=> !dispErrQ);

  // R7: after an offending symbol the tracker equals its polarity (unchanged)
  p_recover_r7: assert property (@(posedge clk) disable iff (!rstN)
    dispHit |=> $stable(rdQ));

endmodule

// File: rtl/dec8b10b.sv
module dec8b10b
  import dec8b10b_pkg::*;
#(
  parameter bit RD_INIT = 1'b0
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic [SYM_W-1:0]  symIn,
  output logic [BYTE_W-1:0] dataOut,
  output logic              kOut,
  output logic              codeErr,
  output logic              dispErr,
  output logic              rxErr
);

  symClass_t symCls;
  dpStrobe_t dpStb;

  dec8b10b_datapath uDatapath (
    .clk    (clk),
    .rstN   (rstN),
    .symIn  (symIn),
    .strobe (dpStb),
    .cls    (symCls),
    .dataQ  (dataOut),
    .kQ     (kOut)
  );

  dec8b10b_control #(.RD_INIT(RD_INIT)) uControl (
    .clk      (clk),
    .rstN     (rstN),
    .cls      (symCls),
    .strobe   (dpStb),
    .codeErrQ (codeErr),
    .dispErrQ (dispErr),
    .rxErrQ   (rxErr)
  );

  // R6: a violation is never also counted as a disparity fault
  p_err_excl_r6: assert property (@(posedge clk) disable iff (!rstN)
    codeErr |-> !dispErr);

  // R6: byte and K outputs are cleared alongside a violation
  p_viol_out_r6: assert property (@(posedge clk) disable iff (!rstN)
    codeErr |-> (dataOut == '0) && !kOut);

  // R8: combined flag never rises without a cause
  p_rx_cause_r8: assert property (@(posedge clk) disable iff (!rstN)
    rxErr |-> (codeErr || dispErr));

endmodule

// File: tb/tb_dec8b10b.sv
`timescale 1ns/1ps
module tb_dec8b10b;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [9:0] symIn = '0;
  logic [7:0] dataOut;
  logic       kOut, codeErr, dispErr, rxErr;

  always #2.5 clk = ~clk;

  dec8b10b dut (
    .clk(clk), .rstN(rstN), .symIn(symIn), .dataOut(dataOut),
    .kOut(kOut), .codeErr(codeErr), .dispErr(dispErr), .rxErr(rxErr)
  );

  typedef struct {
    logic [7:0] b;
    logic       k;
    logic       cv;
    logic       de;
    string      req;
  } exp_t;

  exp_t q[$];
  exp_t monEnt;
  int   checks = 0;
  int   fails  = 0;
  bit   modelRd = 1'b0;
  bit   done = 1'b0;

  // 6-bit codes for negative entry, indexed by low value
  logic [5:0] t6 [32] = '{6'b100111, 6'b011101, 6'b101101, 6'b110001,
                          6'b110101, 6'b101001, 6'b011001, 6'b111000,
                          6'b111001, 6'b100101, 6'b010101, 6'b110100,
                          6'b001101, 6'b101100, 6'b011100, 6'b010111,
                          6'b011011, 6'b100011, 6'b010011, 6'b110010,
                          6'b001011, 6'b101010, 6'b011010, 6'b111010,
                          6'b110011, 6'b100110, 6'b010110, 6'b110110,
                          6'b001110, 6'b101110, 6'b011110, 6'b101011};
  logic [3:0] t4 [8] = '{4'b1011, 4'b1001, 4'b0101, 4'b1100,
                         4'b1101, 4'b1010, 4'b0110, 4'b1110};
  logic [7:0] kBytes [12] = '{8'h1C, 8'h3C, 8'h5C, 8'h7C, 8'h9C, 8'hBC,
                              8'hDC, 8'hFC, 8'hF7, 8'hFB, 8'hFD, 8'hFE};

  bit         legalTbl [1024];
  logic [8:0] decTbl   [1024];

  function automatic logic [9:0] benchEnc(logic [7:0] b, bit k, bit rd);
    logic [5:0] s6;
    logic [3:0] s4;
    bit r;
    int x, y;
    x = int'(b[4:0]);
    y = int'(b[7:5]);
    s6 = (k && x == 28) ? 6'b001111 : t6[x];
    if (rd && ($countones(s6) != 3 || x == 7)) s6 = ~s6;
    r = rd ^ ($countones(s6) != 3);
    if (y == 7 && (k || (!r && (x == 17 || x == 18 || x == 20)) ||
                        (r && (x == 11 || x == 13 || x == 14))))
      s4 = 4'b0111;
    else
      s4 = t4[y];
    if (r && ($countones(s4) != 2 || y == 3)) s4 = ~s4;
    else if (!r && k && x == 28 && $countones(s4) == 2 && y != 3) s4 = ~s4;
    return {s6, s4};
  endfunction

  task automatic report(string req, string what, int act, int expv);
    fails++;
    $display("FAIL %s %s act=%0h exp=%0h", req, what, act, expv);
  endtask

  // driver: computes the expectation from the model, then drives the symbol
  task automatic send(logic [9:0] s, string req);
    exp_t e;
    int ones;
    ones = $countones(s);
    e.req = req;
    if (legalTbl[s]) begin
      e.b  = decTbl[s][7:0];
      e.k  = decTbl[s][8];
      e.cv = 1'b0;
      e.de = (ones == 6 && modelRd) || (ones == 4 && !modelRd);
    end else begin
      e.b = 8'h00; e.k = 1'b0; e.cv = 1'b1; e.de = 1'b0;
    end
    if (ones == 6) modelRd = 1'b1;
    else if (ones == 4) modelRd = 1'b0;
    @(negedge clk);
    symIn = s;
    q.push_back(e);
  endtask

  // monitor: one registered result per driven symbol
  always @(posedge clk) begin
    #1;
    if (q.size() != 0) begin
      monEnt = q.pop_front();
      checks++;
      if (dataOut !== monEnt.b)  report(monEnt.req, "data", int'(dataOut), int'(monEnt.b));
      if (kOut !== monEnt.k)     report(monEnt.req, "kflag", int'(kOut), int'(monEnt.k));
      if (codeErr !== monEnt.cv) report(monEnt.req, "codeErr", int'(codeErr), int'(monEnt.cv));
      if (dispErr !== monEnt.de) report(monEnt.req, "dispErr", int'(dispErr), int'(monEnt.de));
      if (rxErr !== (monEnt.cv | monEnt.de))
        report({monEnt.req, "/R8"}, "rxErr", int'(rxErr), int'(monEnt.cv | monEnt.de));
    end
  end

  initial begin
    #750000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 1024; i++) begin
      legalTbl[i] = 1'b0;
      decTbl[i] = '0;
    end
    for (int rd = 0; rd < 2; rd++) begin
      for (int b = 0; b < 256; b++) begin
        legalTbl[benchEnc(8'(b), 1'b0, rd[0])] = 1'b1;
        decTbl[benchEnc(8'(b), 1'b0, rd[0])] = {1'b0, 8'(b)};
      end
      for (int i = 0; i < 12; i++) begin
        legalTbl[benchEnc(kBytes[i], 1'b1, rd[0])] = 1'b1;
        decTbl[benchEnc(kBytes[i], 1'b1, rd[0])] = {1'b1, kBytes[i]};
      end
    end

    // R1: outputs are zero while reset is held
    repeat (3) @(negedge clk);
    checks++;
    if ({dataOut, kOut, codeErr, dispErr, rxErr} !== 12'h000)
      report("R1", "reset outputs", int'({dataOut, kOut, codeErr, dispErr, rxErr}), 0);
    @(negedge clk);
    rstN = 1'b1;

    // R1: negative start, so a four-ones control symbol is an offence
    send(10'b1100000101, "R1");
    // R3: the two spellings of the comma-style control byte
    send(10'b0011111010, "R3");
    send(10'b1100000101, "R3");

    // R2: every data byte, correctly encoded
    for (int b = 0; b < 256; b++) send(benchEnc(8'(b), 1'b0, modelRd), "R2");

    // R3: all control characters, twice to cover both entry polarities
    for (int p = 0; p < 2; p++)
      for (int i = 0; i < 12; i++) send(benchEnc(kBytes[i], 1'b1, modelRd), "R3");

    // R5 then R7: wrong-column symbol followed by the correct one
    for (int b = 0; b < 256; b++) begin
      send(benchEnc(8'(b), 1'b0, !modelRd), "R5");
      send(benchEnc(8'(b), 1'b0, modelRd), "R7");
    end

    // R4: illegal patterns with six or four ones still move the tracker
    send(10'b1111110000, "R4");
    send(benchEnc(8'h00, 1'b0, 1'b1), "R4");
    send(10'b0000001111, "R4");
    send(benchEnc(8'h00, 1'b0, 1'b0), "R4");
    send(10'b0000001111, "R4");
    send(benchEnc(8'h00, 1'b0, 1'b1), "R4");

    // R6: fixed illegal patterns, then random patterns
    send(10'b0000000000, "R6");
    send(10'b1111111111, "R6");
    send(10'b1110100111, "R6");
    send(10'b0011111111, "R6");
    send(10'b1010101010, "R6");
    for (int n = 0; n < 1500; n++) send(10'($urandom_range(0, 1023)), "R6");

    repeat (3) @(posedge clk);
    #2;
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule